// File: doc/BRIEF.md
# AAL5 Frame Reassembly Checker

This block sits on the receive side of a cell-based link. It takes ATM cells as a stream of 32-bit words, one header word followed by twelve payload words, with the header error byte already stripped. From the header of each cell it works out where AAL5 frames begin and end. It then forwards the words one cycle later, with strobes added for data-enable, start-of-frame and end-of-frame.

The header word stays in the output stream. Start-of-frame marks the header word of a frame's first cell, and data-enable is low on every header word. End-of-frame marks the last user payload word. The two AAL5 trailer words (length word, then CRC word) follow it with data-enable still high.

While words pass through, a CRC-32 is accumulated over the frame. It is compared with the CRC field in the final trailer word. A mismatch raises a one-cycle error flag aligned with that trailer word. A downstream ready signal is passed straight back upstream. Words already presented are forwarded regardless of it.

Top module: `aal5_reasm_check`

## Requirements
- R1: A synchronous active-low reset held for one cycle clears all output strobes to 0. The first valid word after reset is treated as the header word of the first cell of a new frame.
- R2: Each cell is exactly 13 valid input words. The word at position 0 is the header and is output with `out_en` low. Positions 1 to 12 are payload and are output with `out_en` high. Every valid word appears on `out_data` unchanged, one clock after it is presented.
- R3: `out_sof` is high for one cycle, on the header word of the first cell of a frame. That is the first cell after reset, or the cell after one whose header marked it last. It is never high on any other header word.
- R4: A cell is the last cell of its frame when header bit 1 is 1. `out_eof` is high on position 10 of that cell only, which is the word before the two trailer words.
- R5: The check value is a CRC-32 with polynomial 0x04C11DB7, initial value all ones, and each word fed MSB first. It covers every payload word of the frame except position 12 of the last cell. The value is complemented and compared with that final word. If they differ, `out_crc_err` is high for one cycle, together with that word's output.
- R6: Cycles with `in_valid` low do not advance the cell position and produce `out_en`, `out_sof`, `out_eof` and `out_crc_err` all low.
- R7: `up_ready` equals `dn_ready` in the same cycle. Valid input words are forwarded whatever the value of `dn_ready`.
- R8: After the final trailer word of a frame, the CRC restarts from all ones. A failed frame does not affect the check of the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input cell word |
| dn_ready | input | 1 | Downstream can accept words |
| up_ready | output | 1 | Ready passed back upstream |
| out_data | output | 32 | Forwarded word |
| out_en | output | 1 | Payload or trailer word |
| out_sof | output | 1 | Header word of first cell of a frame |
| out_eof | output | 1 | Last user payload word |
| out_crc_err | output | 1 | CRC mismatch, on the final trailer word |

## Verification
A wrong cell position shows up at once as data-enable low on a payload word or high on a header word, within one cell of the error. A wrong last-cell or first-cell flag moves or drops the end-of-frame strobe on the same cell, or moves the start-of-frame strobe on the next header. A corrupted CRC register stays hidden until the final trailer word. It then appears as a missing or false error flag, so frames are sent back to back, both good and bad, to expose state that leaks from one frame into the next.

// File: rtl/aal5_pkg.sv
package aal5_pkg;

   localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

   // Position decode for the word currently on the input
   typedef struct packed {
      logic hdr;   // header word of a cell
      logic sof;   // header word of the first cell of a frame
      logic eof;   // last user payload word
      logic chk;   // word carrying the CRC field
   } pos_t;

   // One 32-bit word through the CRC, most significant bit first
   function automatic logic [31:0] crc32_word(input logic [31:0] crc,
                                              input logic [31:0] d);
      logic [31:0] c;
      logic        fb;
      c = crc;
      for (int i = 31; i >= 0; i--) begin
         fb = c[31] ^ d[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ CRC_POLY;
      end
      return c;
   endfunction

endpackage

// File: rtl/aal5_cell_tracker.sv
module aal5_cell_tracker
   import aal5_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CELL_WORDS = 13,
   parameter int LAST_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output pos_t              pos
);
   localparam int CNT_W   = $clog2(CELL_WORDS);
   localparam int EOF_IDX = CELL_WORDS - 3;
   localparam int CHK_IDX = CELL_WORDS - 1;

   generate
      if (CELL_WORDS < 4) begin : g_bad_cell
         $error("CELL_WORDS must leave room for two trailer words");
      end
      if (LAST_BIT >= DATA_W) begin : g_bad_bit
         $error("LAST_BIT outside the header word");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             first_q;   // next header opens a frame
   logic             last_q;    // current cell closes the frame

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
         last_q  <= 1'b0;
      end else if (in_valid) begin
         if (cnt_q == CNT_W'(CHK_IDX)) begin
            cnt_q   <= '0;
            first_q <= last_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (cnt_q == '0) begin
            last_q  <= in_data[LAST_BIT];
            first_q <= 1'b0;
         end
      end
   end

   always_comb begin
      pos.hdr = (cnt_q == '0);
      pos.sof = pos.hdr && first_q;
      pos.eof = last_q && (cnt_q == CNT_W'(EOF_IDX));
      pos.chk = last_q && (cnt_q == CNT_W'(CHK_IDX));
   end

   // R2: the position never leaves the cell
   a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(CELL_WORDS));
   // R6: idle cycles leave the position alone
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(cnt_q));

endmodule

// File: rtl/aal5_crc_check.sv
module aal5_crc_check
   import aal5_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  pos_t              pos,
   output logic              mismatch
);
   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("CRC datapath is built for 32-bit words");
      end
   endgenerate

   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= '1;
      end else if (in_valid && !pos.hdr) begin
         if (pos.chk) crc_q <= '1;
         else         crc_q <= crc32_word(crc_q, in_data);
      end
   end

   assign mismatch = in_valid && pos.chk && (in_data != ~crc_q);

   // R8: the CRC restarts after every checked frame
   a_r8_crc_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pos.chk) |=> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/aal5_reasm_check.sv
module aal5_reasm_check
   import aal5_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CELL_WORDS = 13,
   parameter int LAST_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              dn_ready,
   output logic              up_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_en,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_crc_err
);
   pos_t pos;
   logic mismatch;

   aal5_cell_tracker #(
      .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .LAST_BIT(LAST_BIT)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .pos(pos)
   );

   aal5_crc_check #(.DATA_W(DATA_W)) u_crc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .pos(pos), .mismatch(mismatch)
   );

   assign up_ready = dn_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data    <= '0;
         out_en      <= 1'b0;
         out_sof     <= 1'b0;
         out_eof     <= 1'b0;
         out_crc_err <= 1'b0;
      end else begin
         out_data    <= in_data;
         out_en      <= in_valid && !pos.hdr;
         out_sof     <= in_valid && pos.sof;
         out_eof     <= in_valid && pos.eof;
         out_crc_err <= mismatch;
      end
   end

   // R3: start-of-frame marks a header, so no data-enable with it
   a_r3_sof_on_header: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> !out_en);
   // R3: a frame start never lasts two cycles
   a_r3_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |=> !out_sof);
   // R4: end-of-frame falls on a payload word
   a_r4_eof_payload: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> out_en);
   // R5: the error flag rides on a trailer word, apart from the other strobes
   a_r5_err_on_trailer: assert property (@(posedge clk) disable iff (!rst_n)
      out_crc_err |-> (out_en && !out_eof && !out_sof));

endmodule

// File: tb/aal5_reasm_check_test.sv
module aal5_reasm_check_test;
   import aal5_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        dn_ready = 1'b1;
   logic        up_ready, out_en, out_sof, out_eof, out_crc_err;
   logic [31:0] out_data;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   aal5_reasm_check uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .dn_ready(dn_ready), .up_ready(up_ready), .out_data(out_data),
      .out_en(out_en), .out_sof(out_sof), .out_eof(out_eof),
      .out_crc_err(out_crc_err)
   );

   // Stimulus table: cells per frame, corrupt CRC, idle gap after each cell, ready
   localparam int NV = 6;
   localparam int T_CELLS [NV] = '{1, 2, 3, 1, 1, 2};
   localparam bit T_BAD   [NV] = '{0, 0, 1, 0, 1, 1};
   localparam int T_GAP   [NV] = '{0, 1, 0, 2, 0, 1};
   localparam bit T_RDY   [NV] = '{1, 0, 1, 0, 1, 1};

   // Bench CRC, byte at a time, MSB first
   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
      logic [31:0] r = c;
      for (int b = 3; b >= 0; b--) begin
         r = r ^ {w[b*8 +: 8], 24'h0};
         for (int k = 0; k < 8; k++)
            r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // Present one valid word, then sample its output one clock later
   task automatic send(input logic [31:0] d, input bit e_en, input bit e_sof,
                       input bit e_eof, input bit e_err);
      in_valid = 1'b1;
      in_data  = d;
      check("R7 up_ready", {31'h0, up_ready}, {31'h0, dn_ready});
      @(negedge clk);
      check("R2 data", out_data, d);
      check("R2 en", {31'h0, out_en}, {31'h0, e_en});
      check("R3 sof", {31'h0, out_sof}, {31'h0, e_sof});
      check("R4 eof", {31'h0, out_eof}, {31'h0, e_eof});
      check("R5 crc_err", {31'h0, out_crc_err}, {31'h0, e_err});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0;
         in_data  = 32'hDEAD_0000 + i;
         @(negedge clk);
         check("R6 idle strobes", {28'h0, out_en, out_sof, out_eof, out_crc_err}, 32'h0);
      end
   endtask

   task automatic send_frame(input int f, input int cells, input bit bad, input int gap);
      logic [31:0] crc = 32'hFFFF_FFFF;
      logic [31:0] d;
      for (int c = 0; c < cells; c++) begin
         bit last = (c == cells - 1);
         send(32'h0123_4500 | {30'h0, last, 1'b0} | (f << 24), 1'b0, c == 0, 1'b0, 1'b0);
         for (int w = 1; w < 13; w++) begin
            if (last && w == 12) begin
               d = ~crc ^ {31'h0, bad};
               send(d, 1'b1, 1'b0, 1'b0, bad);
            end else begin
               d = {f[7:0], c[7:0], w[7:0], 8'h5A} ^ (32'h9E37_79B9 * (w + 1));
               crc = ref_crc(crc, d);
               send(d, 1'b1, 1'b0, last && w == 10, 1'b0);
            end
         end
         idle(gap);
      end
   endtask

   initial begin
      #2000000;
      n_err++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      check("R1 reset strobes", {28'h0, out_en, out_sof, out_eof, out_crc_err}, 32'h0);
      rst_n = 1'b1;

      // Table walk: frame lengths, gaps (R6), ready low (R7), bad CRC (R5),
      // good frame after bad (R8)
      for (int f = 0; f < NV; f++) begin
         dn_ready = T_RDY[f];
         send_frame(f, T_CELLS[f], T_BAD[f], T_GAP[f]);
      end

      // R1: reset in the middle of a cell; the next word opens a fresh frame
      send(32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int w = 1; w < 6; w++) send(32'h1111_0000 + w, 1'b1, 1'b0, 1'b0, 1'b0);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-frame reset", {28'h0, out_en, out_sof, out_eof, out_crc_err}, 32'h0);
      rst_n = 1'b1;
      send_frame(9, 1, 1'b0, 0);

      // R7: ready toggles straight through while idle
      dn_ready = 1'b0;
      #1;
      check("R7 ready low", {31'h0, up_ready}, 32'h0);
      dn_ready = 1'b1;
      #1;
      check("R7 ready high", {31'h0, up_ready}, 32'h1);
      @(negedge clk);
      report();
   end

endmodule